// File: doc/BRIEF.md
# Leading-Edge Boost PWM Generator

This block is the digital core of a boost converter controller whose switching rate is one third of a main clock. A fast clock drives a free-running ramp counter. One full pass of that counter is one main-clock period, and a three-state divider chooses one main period out of every three as the drive window. The drive window is brought out as `clk3_o`.

Inside the window the ramp climbs from 1 to its top value. The gate output is set on the first cycle in which the ramp is greater than the digital error value, and it then stays set until the window closes. Because the gate rises part way through the window and always falls at its end, the modulation is leading-edge, and the duty can never be more than one third.

The control loop gives a digital error level. An enable input starts the converter together with the main 5 V channel. A disable input is asserted when the feedback pin is strapped to the always-on rail. Either of them forces the gate low. The analog error amplifier and the gate driver are outside this block.

Top module: `boost_lepwm`

## Requirements
- R1: While `rst_ni` is low, `gate_o` and `clk3_o` are both 0. The first drive window opens 2·L fast cycles after the internal reset is released, with L = 2^RAMP_W (16 by default).
- R2: `clk3_o` is high for exactly L consecutive cycles and low for exactly 2·L cycles between windows. The timebase keeps running whatever the state of `en_i` and `dis_i`.
- R3: Take `err_i` (unsigned, RAMP_W+1 bits) held constant below L, with `en_i`=1 and `dis_i`=0 at the window start. Then `gate_o` is high for exactly L − `err_i` contiguous cycles that end in the last cycle of the window. In window cycle c (counting from 0) the ramp value is c+1.
- R4: An `err_i` of L or more gives zero high cycles. An `err_i` of 0 gives the whole window, which is the one-third maximum duty.
- R5: Once set within a window, `gate_o` stays high until the window ends, even if `err_i` rises. A drop in `err_i` below the ramp raises `gate_o` in the next cycle.
- R6: `gate_o` is never high while `clk3_o` is low, and it falls in the cycle after the last window cycle.
- R7: If `en_i` is 0 or `dis_i` is 1 at a clock edge, `gate_o` is 0 in the cycle that follows, including in the middle of a window.
- R8: The gate is armed only at a window start. If `en_i` rises or `dis_i` falls in the middle of a window, `gate_o` stays low for the rest of that window. Normal drive resumes at the next window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock; L cycles make one main-clock period |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Converter enable (starts with the 5 V main channel) |
| dis_i | input | 1 | Disable, asserted when the feedback input is strapped high |
| err_i | input | RAMP_W+1 | Unsigned error level compared with the ramp |
| gate_o | output | 1 | Boost switch gate command |
| clk3_o | output | 1 | Divide-by-three drive window, one main period wide |

## Verification
The hardest situations to reach from the ports are changes that land in the middle of a window: a disable after the gate has risen, an enable that arrives after the window has opened, and an error level that rises or falls while the ramp is between its ends. The stimulus waits for `clk3_o` to rise and then counts a fixed number of fast cycles before it moves the input. The expected high-cycle count for that window is therefore known exactly, and the scoreboard compares it when the window closes.

// File: rtl/boost_pwm_pkg.sv
package boost_pwm_pkg;

  // Phases of the three-way main-clock divider; only PH_DRIVE opens the gate window.
  typedef enum logic [1:0] {
    PH_REST_A = 2'd0,
    PH_REST_B = 2'd1,
    PH_DRIVE  = 2'd2
  } div_phase_e;

  function automatic div_phase_e next_phase(input div_phase_e cur);
    case (cur)
      PH_REST_A: return PH_REST_B;
      PH_REST_B: return PH_DRIVE;
      default:   return PH_REST_A;
    endcase
  endfunction

endpackage

// File: rtl/boost_rst_sync.sv
module boost_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/boost_ramp_timer.sv
module boost_ramp_timer #(
  parameter int RAMP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [RAMP_W-1:0] cnt_next_o,
  output logic              period_end_o
);

  logic [RAMP_W-1:0] cnt_q;
  logic [RAMP_W-1:0] cnt_d;

  // One wrap of the counter is one main-clock period.
  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_next_o   = cnt_d;
  assign period_end_o = &cnt_q;

endmodule

// File: rtl/boost_div3.sv
module boost_div3
  import boost_pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       period_end_i,
  output div_phase_e phase_next_o,
  output logic       win_o
);

  div_phase_e phase_q;
  div_phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (period_end_i) phase_d = next_phase(phase_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_REST_A;
    else         phase_q <= phase_d;
  end

  assign phase_next_o = phase_d;
  assign win_o        = (phase_q == PH_DRIVE);

endmodule

// File: rtl/boost_gate_latch.sv
module boost_gate_latch #(
  parameter int RAMP_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            dis_i,
  input  logic            win_next_i,
  input  logic            win_start_next_i,
  input  logic [RAMP_W:0] ramp_next_i,
  input  logic [RAMP_W:0] err_i,
  output logic            gate_o
);

  logic run_ok;
  logic trip;
  logic arm_q, arm_d;
  logic gate_q, gate_d;

  always_comb begin
    run_ok = en_i & ~dis_i;
    // Arming happens only at a window start; any stop drops it at once.
    arm_d  = run_ok & (win_start_next_i | arm_q);
    trip   = (ramp_next_i > err_i);
    // Set by the comparison, held until the window closes.
    gate_d = arm_d & win_next_i & (gate_q | trip);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/boost_lepwm.sv
module boost_lepwm
  import boost_pwm_pkg::*;
#(
  parameter int RAMP_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            dis_i,
  input  logic [RAMP_W:0] err_i,
  output logic            gate_o,
  output logic            clk3_o
);

  logic              rst_int_n;
  logic [RAMP_W-1:0] cnt_next;
  logic              period_end;
  div_phase_e        phase_next;
  logic              win_q;
  logic              win_next;
  logic              win_start_next;
  logic [RAMP_W:0]   ramp_next;

  boost_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  boost_ramp_timer #(.RAMP_W(RAMP_W)) u_ramp_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .cnt_next_o   (cnt_next),
    .period_end_o (period_end)
  );

  boost_div3 u_div3 (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .period_end_i (period_end),
    .phase_next_o (phase_next),
    .win_o        (win_q)
  );

  always_comb begin
    win_next       = (phase_next == PH_DRIVE);
    win_start_next = win_next & period_end;
    ramp_next      = {1'b0, cnt_next} + {{RAMP_W{1'b0}}, 1'b1};
  end

  boost_gate_latch #(.RAMP_W(RAMP_W)) u_gate_latch (
    .clk_i            (clk_i),
    .rst_ni           (rst_int_n),
    .en_i             (en_i),
    .dis_i            (dis_i),
    .win_next_i       (win_next),
    .win_start_next_i (win_start_next),
    .ramp_next_i      (ramp_next),
    .err_i            (err_i),
    .gate_o           (gate_o)
  );

  assign clk3_o = win_q;

endmodule

// File: rtl/boost_lepwm_chk.sv
module boost_lepwm_chk #(
  parameter int RAMP_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            dis_i,
  input logic [RAMP_W:0] err_i,
  input logic            gate_o,
  input logic            clk3_o
);

  localparam logic [RAMP_W:0]   LEN_V = (RAMP_W+1)'(1) << RAMP_W;
  localparam logic [RAMP_W+2:0] GAP_V = (RAMP_W+3)'(2) << RAMP_W;

  logic [RAMP_W:0]   hi_run_q;
  logic [RAMP_W+2:0] lo_run_q;
  logic              seen_fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q    <= '0;
      lo_run_q    <= '0;
      seen_fall_q <= 1'b0;
    end else begin
      hi_run_q    <= clk3_o ? hi_run_q + 1'b1 : '0;
      lo_run_q    <= clk3_o ? '0 : ((&lo_run_q) ? lo_run_q : lo_run_q + 1'b1);
      seen_fall_q <= seen_fall_q | (~clk3_o & (hi_run_q != '0));
    end
  end

  p_gate_in_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> clk3_o);

  p_window_short_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk3_o |-> (hi_run_q < LEN_V));

  p_window_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk3_o) |-> (hi_run_q == LEN_V));

  p_window_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_fall_q && $rose(clk3_o)) |-> (lo_run_q == GAP_V));

  p_force_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || dis_i) |=> !gate_o);

  p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && en_i && !dis_i && clk3_o) |=> (gate_o || !clk3_o));

  p_zero_duty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_o && (err_i >= LEN_V)) |=> !gate_o);

  p_late_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(en_i) && !dis_i && clk3_o) |=> !gate_o);

endmodule

bind boost_lepwm boost_lepwm_chk #(.RAMP_W(RAMP_W)) u_boost_lepwm_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .dis_i  (dis_i),
  .err_i  (err_i),
  .gate_o (gate_o),
  .clk3_o (clk3_o)
);

// File: tb/boost_lepwm_bench.sv
module boost_lepwm_bench;

  localparam int RW = 4;
  localparam int L  = 1 << RW;

  logic          clk;
  logic          rst_ni;
  logic          en;
  logic          dis;
  logic [RW:0]   err;
  logic          gate;
  logic          clk3;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit mon_on   = 0;

  int    exp_cnt_q[$];
  bit    exp_shape_q[$];
  string exp_tag_q[$];

  boost_lepwm #(.RAMP_W(RW)) u_boost_lepwm (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en),
    .dis_i  (dis),
    .err_i  (err),
    .gate_o (gate),
    .clk3_o (clk3)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: measures each window and compares with the scoreboard entry.
  bit prev_win = 0, have_win = 0, last_gate = 0, fell = 0, stray = 0;
  int hi = 0, lo = 0, g = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (clk3) begin
        if (!prev_win) begin
          if (have_win) check(lo == 2*L, "R2", "gap cycles", lo, 2*L);
          lo = 0; hi = 0; g = 0; fell = 0; last_gate = 0;
        end
        hi++;
        if (last_gate && !gate) fell = 1;
        if (gate) g++;
        last_gate = gate;
      end else begin
        if (gate) stray = 1;
        if (prev_win) begin
          have_win = 1;
          check(hi == L, "R2", "window length", hi, L);
          if (exp_cnt_q.size() > 0) begin
            int    e;
            bit    s;
            string t;
            e = exp_cnt_q.pop_front();
            s = exp_shape_q.pop_front();
            t = exp_tag_q.pop_front();
            check(g == e, t, "gate high cycles", g, e);
            if (s) check(!fell && (g == 0 || last_gate), "R3",
                         "gate run not ending at window end", int'(fell), 0);
          end
          check(!stray, "R6", "gate high outside window", int'(stray), 0);
          stray = 0;
        end
        lo++;
      end
      prev_win = clk3;
    end
  end

  task automatic wait_win_end();
    bit p;
    p = clk3;
    forever begin
      @(negedge clk);
      if (p && !clk3) break;
      p = clk3;
    end
    @(negedge clk);
  endtask

  task automatic wait_win_start();
    while (!clk3) @(negedge clk);
  endtask

  task automatic apply(input int e, input bit en_v, input bit dis_v,
                       input int exp, input bit shaped, input string tag);
    wait_win_end();
    err = (RW+1)'(e);
    en  = en_v;
    dis = dis_v;
    exp_cnt_q.push_back(exp);
    exp_shape_q.push_back(shaped);
    exp_tag_q.push_back(tag);
  endtask

  initial begin
    rst_ni = 1'b0; en = 1'b0; dis = 1'b0; err = '0;
    repeat (5) @(negedge clk);
    check(gate == 1'b0, "R1", "gate in reset", int'(gate), 0);
    check(clk3 == 1'b0, "R1", "window in reset", int'(clk3), 0);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    repeat (3) @(negedge clk);
    check(gate == 1'b0 && clk3 == 1'b0, "R1", "outputs just after reset",
          int'(gate) + int'(clk3), 0);

    apply(0,  1, 0, L,      1, "R4");
    apply(L,  1, 0, 0,      1, "R4");
    apply(31, 1, 0, 0,      1, "R4");
    apply(1,  1, 0, L - 1,  1, "R3");
    apply(5,  1, 0, L - 5,  1, "R3");
    apply(15, 1, 0, L - 15, 1, "R3");
    apply(0,  1, 1, 0,      1, "R7");
    apply(0,  0, 0, 0,      1, "R7");

    // Disable after the gate rose in window cycle 0: high for cycles 0..3.
    apply(0, 1, 0, 4, 0, "R7");
    wait_win_start();
    repeat (3) @(negedge clk);
    dis = 1'b1;
    @(negedge clk);
    check(gate == 1'b0, "R7", "gate after mid-window disable", int'(gate), 0);

    // Enable arriving in window cycle 2: the window stays dark.
    apply(0, 0, 0, 0, 1, "R8");
    wait_win_start();
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check(gate == 1'b0, "R8", "gate after late enable", int'(gate), 0);
    apply(8, 1, 0, L - 8, 1, "R8");

    // Error rises after the gate set: latch holds (cycles 8..15).
    apply(8, 1, 0, 8, 1, "R5");
    wait_win_start();
    repeat (10) @(negedge clk);
    err = (RW+1)'(31);

    // Error falls in cycle 4: gate rises in cycle 5 (cycles 5..15).
    apply(31, 1, 0, 11, 1, "R5");
    wait_win_start();
    repeat (4) @(negedge clk);
    err = '0;

    wait_win_end();
    repeat (2) @(negedge clk);
    check(exp_cnt_q.size() == 0, "R3", "scoreboard left over", exp_cnt_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule